// File: doc/BRIEF.md
# Inbound Vendor Message Holding Register

This block sits at the head of an inbound posted-transaction queue. Each transaction on its input carries a type field, an 8-bit message code and a 64-bit payload. Transactions whose type marks them as vendor-defined messages are taken off the stream into a single holding register, which software reads through dedicated outputs. All other transactions flow straight to the output with no added register stage.

While the holding register is occupied, a later vendor message is handled by a one-bit overflow policy. With the policy in drop mode, which is its reset value, the message is accepted and discarded, and a saturating counter records the loss. With the policy in block mode, the message waits at the head of the queue and holds back every transaction behind it until software frees the register.

Drop mode exists for one case. Software may have to see a read completion before it can service the message interrupt, and that completion may sit behind the blocked message. Software frees the register with a one-cycle release strobe. A blocked message is captured in the cycle after the release.

Top module: `ivm_gate`

## Requirements
- R1: When the head transaction is not a vendor message (type code 2'b11), out_valid equals in_valid, in_ready equals out_ready, and the output type, code and payload equal the input in the same cycle.
- R2: A vendor message presented while the holding register is empty is accepted (in_ready high). From the next cycle, msg_pending is high and msg_code/msg_data hold its code and payload.
- R3: msg_irq is high for exactly one cycle, the first cycle in which msg_pending is high after a capture.
- R4: With the policy in drop mode and msg_pending high, a vendor message is accepted and discarded. The held code and payload do not change and drop_count increases by one.
- R5: With the policy in block mode and msg_pending high, a vendor message at the head is not accepted (in_ready low) and nothing is forwarded (out_valid low).
- R6: A sw_release pulse while msg_pending is high clears msg_pending at the next edge, unless a capture occurs in that cycle. A message blocked during the release cycle is accepted in the following cycle.
- R7: drop_count is 0 after reset, counts discarded messages, and stays at 255 once there.
- R8: The overflow policy is drop mode after reset. A cycle with pol_we high loads pol_drop into it (1 = drop, 0 = block).
- R9: A vendor message never appears on the output: out_valid is never high with out_kind equal to 2'b11.
- R10: After reset, msg_pending, msg_irq and drop_count are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Head transaction valid |
| in_ready | output | 1 | Head transaction accepted this cycle |
| in_kind | input | 2 | Transaction type, 2'b11 = vendor message |
| in_code | input | 8 | Message code |
| in_data | input | 64 | Payload |
| out_valid | output | 1 | Forwarded transaction valid |
| out_ready | input | 1 | Downstream ready |
| out_kind | output | 2 | Forwarded type |
| out_code | output | 8 | Forwarded code |
| out_data | output | 64 | Forwarded payload |
| pol_we | input | 1 | Policy write strobe |
| pol_drop | input | 1 | Policy value, 1 = drop, 0 = block |
| sw_release | input | 1 | Software release of the holding register |
| msg_pending | output | 1 | Holding register occupied |
| msg_code | output | 8 | Held message code |
| msg_data | output | 64 | Held message payload |
| msg_irq | output | 1 | One-cycle interrupt on capture |
| drop_count | output | 8 | Saturating count of discarded messages |

## Verification
The assertions assume that reset is applied for at least one clock before checking matters. They also assume that sw_release, pol_we and the head fields are stable across each sampling edge. They do not assume that the upstream holds a stalled message: the block's own accept decision is checked every cycle whatever the source does next. The bench drives every input half a cycle away from the edge. Its random stimulus keeps presenting the same message while it is refused, which mirrors a real queue head and exercises the blocked-then-captured path.

// File: rtl/ivm_pkg.sv
package ivm_pkg;
    localparam int KIND_W = 2;
    localparam int CODE_W = 8;
    localparam int DATA_W = 64;
    localparam int CNT_W  = 8;

    typedef enum logic [KIND_W-1:0] {
        K_MWR  = 2'b00,
        K_CPL  = 2'b01,
        K_OTH  = 2'b10,
        K_VMSG = 2'b11
    } kind_e;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [DATA_W-1:0] data;
    } vmsg_t;

    typedef enum logic [1:0] {
        RT_PASS = 2'd0,
        RT_TAKE = 2'd1,
        RT_DROP = 2'd2,
        RT_HOLD = 2'd3
    } route_e;

    function automatic logic is_vmsg(input logic [KIND_W-1:0] k);
        return k == K_VMSG;
    endfunction
endpackage

// File: rtl/ivm_route.sv
module ivm_route
    import ivm_pkg::*;
(
    input  logic              in_valid,
    input  logic [KIND_W-1:0] in_kind,
    input  logic              pending,
    input  logic              drop_mode,
    input  logic              out_ready,
    output route_e            route,
    output logic              in_ready,
    output logic              out_valid
);
    logic head_msg;

    always_comb begin
        head_msg = in_valid && is_vmsg(in_kind);
        if (!head_msg)
            route = RT_PASS;
        else if (!pending)
            route = RT_TAKE;
        else if (drop_mode)
            route = RT_DROP;
        else
            route = RT_HOLD;
    end

    always_comb begin
        unique case (route)
            RT_PASS: begin
                in_ready  = out_ready;
                out_valid = in_valid;
            end
            RT_TAKE, RT_DROP: begin
                in_ready  = 1'b1;
                out_valid = 1'b0;
            end
            default: begin
                in_ready  = 1'b0;
                out_valid = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/ivm_hold.sv
module ivm_hold
    import ivm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  take,
    input  logic  release_i,
    input  vmsg_t in_msg,
    output logic  pending,
    output vmsg_t held,
    output logic  irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
            held    <= '0;
            irq     <= 1'b0;
        end else begin
            irq <= take;
            if (take) begin
                pending <= 1'b1;
                held    <= in_msg;
            end else if (release_i) begin
                pending <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/ivm_sat_ctr.sv
module ivm_sat_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (inc && count != TOP)
            count <= count + 1'b1;
    end
endmodule

// File: rtl/ivm_gate.sv
module ivm_gate
    import ivm_pkg::*;
#(
    parameter logic DROP_AT_RST = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [KIND_W-1:0] in_kind,
    input  logic [CODE_W-1:0] in_code,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [KIND_W-1:0] out_kind,
    output logic [CODE_W-1:0] out_code,
    output logic [DATA_W-1:0] out_data,
    input  logic              pol_we,
    input  logic              pol_drop,
    input  logic              sw_release,
    output logic              msg_pending,
    output logic [CODE_W-1:0] msg_code,
    output logic [DATA_W-1:0] msg_data,
    output logic              msg_irq,
    output logic [CNT_W-1:0]  drop_count
);
    logic   drop_q;
    route_e route;
    vmsg_t  in_msg;
    vmsg_t  held;

    always_ff @(posedge clk) begin
        if (rst)
            drop_q <= DROP_AT_RST;
        else if (pol_we)
            drop_q <= pol_drop;
    end

    assign in_msg = '{code: in_code, data: in_data};

    ivm_route u_route (
        .in_valid  (in_valid),
        .in_kind   (in_kind),
        .pending   (msg_pending),
        .drop_mode (drop_q),
        .out_ready (out_ready),
        .route     (route),
        .in_ready  (in_ready),
        .out_valid (out_valid)
    );

    ivm_hold u_hold (
        .clk       (clk),
        .rst       (rst),
        .take      (route == RT_TAKE),
        .release_i (sw_release),
        .in_msg    (in_msg),
        .pending   (msg_pending),
        .held      (held),
        .irq       (msg_irq)
    );

    ivm_sat_ctr #(.W(CNT_W)) u_drops (
        .clk   (clk),
        .rst   (rst),
        .inc   (route == RT_DROP),
        .count (drop_count)
    );

    assign msg_code = held.code;
    assign msg_data = held.data;
    assign out_kind = in_kind;
    assign out_code = in_code;
    assign out_data = in_data;
endmodule

// File: rtl/ivm_gate_chk.sv
module ivm_gate_chk
    import ivm_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic [KIND_W-1:0] in_kind,
    input logic              out_valid,
    input logic              out_ready,
    input logic [KIND_W-1:0] out_kind,
    input logic              sw_release,
    input logic              msg_pending,
    input logic [CODE_W-1:0] msg_code,
    input logic [DATA_W-1:0] msg_data,
    input logic              msg_irq,
    input logic [CNT_W-1:0]  drop_count,
    input logic              drop_q
);
    a_r1_pass_through: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_kind != K_VMSG) |-> (out_valid && in_ready == out_ready));

    a_r9_no_msg_out: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_kind != K_VMSG);

    a_r5_block_head: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_kind == K_VMSG && msg_pending && !drop_q) |-> (!in_ready && !out_valid));

    a_r4_held_stable: assert property (@(posedge clk) disable iff (rst)
        (msg_pending && !sw_release) |=> (msg_pending && $stable(msg_code) && $stable(msg_data)));

    a_r3_irq_single: assert property (@(posedge clk) disable iff (rst)
        msg_irq |=> !msg_irq);

    a_r3_irq_on_rise: assert property (@(posedge clk) disable iff (rst)
        msg_irq |-> msg_pending);

    a_r6_release_frees: assert property (@(posedge clk) disable iff (rst)
        (sw_release && msg_pending) |=> !msg_pending);

    a_r7_saturate: assert property (@(posedge clk) disable iff (rst)
        (drop_count == 8'hFF) |=> (drop_count == 8'hFF));
endmodule

bind ivm_gate ivm_gate_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_kind     (in_kind),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_kind    (out_kind),
    .sw_release  (sw_release),
    .msg_pending (msg_pending),
    .msg_code    (msg_code),
    .msg_data    (msg_data),
    .msg_irq     (msg_irq),
    .drop_count  (drop_count),
    .drop_q      (drop_q)
);

// File: tb/ivm_gate_bench.sv
module ivm_gate_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid, in_ready;
    logic [1:0]  in_kind;
    logic [7:0]  in_code;
    logic [63:0] in_data;
    logic        out_valid, out_ready;
    logic [1:0]  out_kind;
    logic [7:0]  out_code;
    logic [63:0] out_data;
    logic        pol_we, pol_drop, sw_release;
    logic        msg_pending, msg_irq;
    logic [7:0]  msg_code, drop_count;
    logic [63:0] msg_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    logic        m_pend, m_irq, m_drop;
    logic [7:0]  m_code, m_cnt;
    logic [63:0] m_data;

    always #5 clk = ~clk;

    ivm_gate u_ivm_gate (.*);

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic exp_ready(input logic v, input logic [1:0] k, input logic ordy);
        if (v && k == 2'b11) return !m_pend || m_drop;
        return ordy;
    endfunction

    task automatic cyc(input logic v, input logic [1:0] k, input logic [7:0] c,
                       input logic [63:0] d, input logic ordy, input logic rel,
                       input logic pwe, input logic pval);
        logic is_m, take, drp;
        @(negedge clk);
        in_valid = v; in_kind = k; in_code = c; in_data = d;
        out_ready = ordy; sw_release = rel; pol_we = pwe; pol_drop = pval;
        #1;
        is_m = v && k == 2'b11;
        // registered state against model
        chk("R6", {63'd0, msg_pending}, {63'd0, m_pend});
        chk("R3", {63'd0, msg_irq}, {63'd0, m_irq});
        chk("R7", {56'd0, drop_count}, {56'd0, m_cnt});
        if (m_pend) begin
            chk("R4", {56'd0, msg_code}, {56'd0, m_code});
            chk("R4", msg_data, m_data);
        end
        // combinational routing
        chk(is_m ? (m_pend ? (m_drop ? "R4" : "R5") : "R2") : "R1",
            {63'd0, in_ready}, {63'd0, exp_ready(v, k, ordy)});
        chk(is_m ? "R9" : "R1", {63'd0, out_valid}, {63'd0, v && !is_m});
        if (v && !is_m) begin
            chk("R1", {62'd0, out_kind}, {62'd0, k});
            chk("R1", {56'd0, out_code}, {56'd0, c});
            chk("R1", out_data, d);
        end
        take = is_m && !m_pend;
        drp  = is_m && m_pend && m_drop;
        @(posedge clk);
        m_irq = take;
        if (take) begin
            m_pend = 1'b1; m_code = c; m_data = d;
        end else if (rel) begin
            m_pend = 1'b0;
        end
        if (drp && m_cnt != 8'hFF) m_cnt = m_cnt + 8'd1;
        if (pwe) m_drop = pval;
    endtask

    task automatic idle();
        cyc(1'b0, 2'b00, 8'h0, 64'h0, 1'b1, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1D5E_0042));
        rst = 1'b1;
        in_valid = 0; in_kind = 0; in_code = 0; in_data = 0;
        out_ready = 0; sw_release = 0; pol_we = 0; pol_drop = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_pend = 0; m_irq = 0; m_drop = 1; m_cnt = 0; m_code = 0; m_data = 0;
        #1;
        // R10 reset state
        chk("R10", {63'd0, msg_pending}, 64'd0);
        chk("R10", {63'd0, msg_irq}, 64'd0);
        chk("R10", {56'd0, drop_count}, 64'd0);

        // R8: default drop mode: capture, then a second message is discarded
        cyc(1'b1, 2'b11, 8'hA5, 64'h1111_2222_3333_4444, 1'b1, 0, 0, 0);
        cyc(1'b1, 2'b11, 8'h5A, 64'hDEAD_BEEF_0000_0001, 1'b1, 0, 0, 0);
        #1;
        chk("R8", {56'd0, drop_count}, 64'd1);
        chk("R8", {56'd0, msg_code}, 64'hA5);

        // R5: block mode, message stalls, traffic behind it held
        cyc(1'b0, 2'b00, 8'h0, 64'h0, 1'b1, 0, 1, 0);
        repeat (3) cyc(1'b1, 2'b11, 8'h77, 64'h7777, 1'b1, 0, 0, 0);
        // R6: release during block, captured next cycle
        cyc(1'b1, 2'b11, 8'h77, 64'h7777, 1'b1, 1, 0, 0);
        cyc(1'b1, 2'b11, 8'h77, 64'h7777, 1'b1, 0, 0, 0);
        #1;
        chk("R6", {63'd0, msg_pending}, 64'd1);
        chk("R6", {56'd0, msg_code}, 64'h77);
        chk("R3", {63'd0, msg_irq}, 64'd1);
        idle();

        // R1: pass-through with downstream stall and go
        cyc(1'b1, 2'b00, 8'h10, 64'hCAFE, 1'b0, 0, 0, 0);
        cyc(1'b1, 2'b01, 8'h20, 64'hF00D, 1'b1, 0, 0, 0);
        cyc(1'b1, 2'b10, 8'h30, 64'hBEEF, 1'b1, 0, 0, 0);

        // R7: saturation in drop mode
        cyc(1'b0, 2'b00, 8'h0, 64'h0, 1'b1, 0, 1, 1);
        for (int i = 0; i < 260; i++)
            cyc(1'b1, 2'b11, i[7:0], {32'd0, i}, 1'b1, 0, 0, 0);
        #1;
        chk("R7", {56'd0, drop_count}, 64'hFF);
        cyc(1'b0, 2'b00, 8'h0, 64'h0, 1'b1, 1, 0, 0);

        // random mix
        begin
            logic        hv;
            logic [1:0]  hk;
            logic [7:0]  hc;
            logic [63:0] hd;
            hv = 0; hk = 0; hc = 0; hd = 0;
            for (int i = 0; i < 3000; i++) begin
                logic rel, pwe, pval, ordy, acc;
                if (!hv || $urandom_range(0, 3) == 0) begin
                    hv = $urandom_range(0, 4) != 0;
                    hk = ($urandom_range(0, 9) < 4) ? 2'b11 : 2'($urandom_range(0, 2));
                    hc = 8'($urandom);
                    hd = {$urandom, $urandom};
                end
                rel  = $urandom_range(0, 9) == 0;
                pwe  = $urandom_range(0, 49) == 0;
                pval = 1'($urandom);
                ordy = $urandom_range(0, 3) != 0;
                acc  = hv && exp_ready(hv, hk, ordy);
                cyc(hv, hk, hc, hd, ordy, rel, pwe, pval);
                if (acc) hv = 0;
            end
        end
        idle();

        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule